// File: doc/BRIEF.md
# Serial EEPROM Image Loader with Size Detection

This block runs once after reset. It reads the whole contents of a three-wire serial EEPROM that holds 16-bit words. The wires are a shift clock, a chip select, a serial command line to the memory, and a serial data line back from it. The block does not know the device size in advance. Its first access is a read framed for the larger address width, and the pattern returned during that access tells it whether the device holds 256 words (8-bit address) or 64 words (6-bit address).

After sizing, the block reads every word from address 0 upward. Each word is its own chip-select access. It keeps a 16-bit modular sum of all the words and raises a flag when that sum matches a fixed signature. The first three words are captured as a 48-bit station address, with the bytes inside each word swapped. A done flag then rises and the serial interface goes quiet until the next reset.

All serial timing comes from a parameterized tick: each clock half-period, and the chip-select-low gap between accesses, lasts at least `TICK_CYC` system clocks. The returning data line passes through a short synchronizer before it is sampled.

Top module: `ee_autosize_reader`

## Requirements
- R1: While `rst_ni` is low, chip select, shift clock, `done_o` and `sum_ok_o` are 0 and `station_addr_o` is all zeros.
- R2: Every access is 28 shift-clock periods long. Command bits go out MSB first: zero padding, then a start bit of 1 and the rest of the read opcode `110`, then the address, then 16 clocks during which data returns. There is one pad bit with an 8-bit address and three pad bits with a 6-bit address.
- R3: The first access after reset reads word 0 with an 8-bit address. If bits 27:17 of its 28-bit response are all ones, the device is taken as 256 words. Otherwise it is taken as 64 words. After the probe, exactly that many read accesses follow.
- R4: The read accesses cover addresses 0, 1, 2, ... up to the last word, in ascending order. Each uses the detected address width.
- R5: `sum_ok_o` is 1 only when `done_o` is 1 and the 16-bit wraparound sum of all words equals 16'hBABA.
- R6: `station_addr_o` holds words 0, 1 and 2 with the low byte of each word ahead of its high byte. Bits 47:40 are the low byte of word 0, and bits 7:0 are the high byte of word 2.
- R7: The shift clock is high only while chip select is high. Chip select rises while the shift clock is low.
- R8: Every high and every low shift-clock phase inside an access lasts at least `TICK_CYC` clocks. Chip select stays low at least `TICK_CYC` clocks between accesses.
- R9: `done_o` rises after the last word has been summed and then stays high. No further access starts once it is high.
- R10: Reset during a run aborts the current access and restarts from the probe step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ee_sk_o | output | 1 | Serial shift clock to the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_di_o | output | 1 | Serial command/address bits to the EEPROM |
| ee_do_i | input | 1 | Serial data returned by the EEPROM |
| done_o | output | 1 | Whole image read and summed |
| sum_ok_o | output | 1 | Image sum matches the signature (valid with done) |
| station_addr_o | output | 48 | Station address assembled from words 0 to 2 |

## Verification
A wrong size decision shows up within one access after the probe. The pad count and address width of the second access are off, and the final access count becomes 65 instead of 257 or the reverse. An address counter that skips or repeats a value is caught at the port as an out-of-order address in the access log, and it also corrupts the sum flag at the end of the run. A byte-swap or word-slot fault in the address capture stays hidden until `done_o` rises, when `station_addr_o` is compared. A phase-timer fault shows up in the first access as a short clock phase or a short chip-select gap.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;
  localparam int DATA_W    = 16;
  localparam int OPC_W     = 3;
  localparam logic [OPC_W-1:0] RD_OPC = 3'b110;
  localparam int STA_WORDS = 3;
  localparam int STA_W     = STA_WORDS * DATA_W;

  typedef enum logic [2:0] {
    SH_IDLE, SH_LOW, SH_HIGH, SH_TAIL, SH_GAP
  } sh_state_e;

  typedef enum logic [2:0] {
    SQ_PROBE_REQ, SQ_PROBE_WAIT, SQ_READ_REQ, SQ_READ_WAIT, SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/ee_tick_gen.sv
module ee_tick_gen #(
  parameter int TICK_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(TICK_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_in_sync.sv
module ee_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ee_frame_shifter.sv
module ee_frame_shifter
  import ee_rd_pkg::*;
#(
  parameter int FRAME_W     = 28,
  parameter int TICK_CYC    = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               ee_do_i,
  output logic               ee_sk_o,
  output logic               ee_cs_o,
  output logic               ee_di_o,
  output logic               busy_o,
  output logic               resp_vld_o,
  output logic [FRAME_W-1:0] resp_o
);
  localparam int BIT_W = $clog2(FRAME_W);

  sh_state_e          state_q, state_d;
  logic [FRAME_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               vld_d, tick, do_s;
  logic               sk_q, cs_q, di_q;

  ee_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != SH_IDLE),
    .tick_o (tick)
  );

  ee_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ee_do_i),
    .q_o    (do_s)
  );

  always_comb begin
    state_d = state_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    vld_d   = 1'b0;
    unique case (state_q)
      SH_IDLE: if (start_i) begin
        tx_d    = frame_i;
        rx_d    = '0;
        bit_d   = BIT_W'(FRAME_W - 1);
        state_d = SH_LOW;
      end
      SH_LOW:  if (tick) state_d = SH_HIGH;
      SH_HIGH: if (tick) begin
        // sample at the end of the high phase, then present the next bit
        rx_d = {rx_q[FRAME_W-2:0], do_s};
        tx_d = {tx_q[FRAME_W-2:0], 1'b0};
        if (bit_q == '0) state_d = SH_TAIL;
        else begin
          bit_d   = bit_q - 1'b1;
          state_d = SH_LOW;
        end
      end
      SH_TAIL: if (tick) state_d = SH_GAP;
      SH_GAP:  if (tick) begin
        state_d = SH_IDLE;
        vld_d   = 1'b1;
      end
      default: state_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SH_IDLE;
      tx_q       <= '0;
      rx_q       <= '0;
      bit_q      <= '0;
      resp_vld_o <= 1'b0;
      sk_q       <= 1'b0;
      cs_q       <= 1'b0;
      di_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      tx_q       <= tx_d;
      rx_q       <= rx_d;
      bit_q      <= bit_d;
      resp_vld_o <= vld_d;
      sk_q       <= (state_d == SH_HIGH);
      cs_q       <= (state_d == SH_LOW) || (state_d == SH_HIGH) || (state_d == SH_TAIL);
      di_q       <= ((state_d == SH_LOW) || (state_d == SH_HIGH)) && tx_d[FRAME_W-1];
    end
  end

  assign ee_sk_o = sk_q;
  assign ee_cs_o = cs_q;
  assign ee_di_o = di_q;
  assign busy_o  = (state_q != SH_IDLE);
  assign resp_o  = rx_q;
endmodule

// File: rtl/ee_image_check.sv
module ee_image_check
  import ee_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [STA_W-1:0]  station_o
);
  localparam int HB = DATA_W / 2;

  logic [DATA_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sum_q <= '0;
    else if (word_vld_i) sum_q <= sum_q + word_i;
  end

  assign sum_o = sum_q;

  generate
    for (genvar g = 0; g < STA_WORDS; g++) begin : g_sta
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          slot_q <= '0;
        else if (word_vld_i && addr_i == AW'(g))
          slot_q <= {word_i[HB-1:0], word_i[DATA_W-1:HB]};
      end
      // word 0 lands in the most significant slot
      assign station_o[(STA_WORDS-1-g)*DATA_W +: DATA_W] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/ee_autosize_reader.sv
module ee_autosize_reader
  import ee_rd_pkg::*;
#(
  parameter int              TICK_CYC    = 125,
  parameter int              SYNC_STAGES = 2,
  parameter int              AW_L        = 8,
  parameter int              AW_S        = 6,
  parameter logic [15:0]     SIGNATURE   = 16'hBABA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             ee_sk_o,
  output logic             ee_cs_o,
  output logic             ee_di_o,
  input  logic             ee_do_i,
  output logic             done_o,
  output logic             sum_ok_o,
  output logic [STA_W-1:0] station_addr_o
);
  localparam int FRAME_W = 1 + OPC_W + AW_L + DATA_W;
  localparam int PAD_S   = 1 + AW_L - AW_S;
  localparam logic [AW_L-1:0] LAST_S = AW_L'((1 << AW_S) - 1);

  seq_state_e         sq_q;
  logic               wide_q, done_q;
  logic [AW_L-1:0]    addr_q;
  logic               start, busy, resp_vld, word_vld;
  logic [FRAME_W-1:0] frame, resp;
  logic [DATA_W-1:0]  sum;
  logic [AW_L-1:0]    last_addr;

  function automatic logic [FRAME_W-1:0] build_frame(input logic wide,
                                                     input logic [AW_L-1:0] a);
    if (wide) return {1'b0, RD_OPC, a, {DATA_W{1'b0}}};
    else      return {{PAD_S{1'b0}}, RD_OPC, a[AW_S-1:0], {DATA_W{1'b0}}};
  endfunction

  assign start     = ((sq_q == SQ_PROBE_REQ) || (sq_q == SQ_READ_REQ)) && !busy;
  assign frame     = (sq_q == SQ_PROBE_REQ) ? build_frame(1'b1, '0)
                                            : build_frame(wide_q, addr_q);
  assign last_addr = wide_q ? '1 : LAST_S;
  assign word_vld  = (sq_q == SQ_READ_WAIT) && resp_vld;

  ee_frame_shifter #(
    .FRAME_W     (FRAME_W),
    .TICK_CYC    (TICK_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .frame_i    (frame),
    .ee_do_i    (ee_do_i),
    .ee_sk_o    (ee_sk_o),
    .ee_cs_o    (ee_cs_o),
    .ee_di_o    (ee_di_o),
    .busy_o     (busy),
    .resp_vld_o (resp_vld),
    .resp_o     (resp)
  );

  ee_image_check #(.AW(AW_L)) u_img (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_vld_i (word_vld),
    .addr_i     (addr_q),
    .word_i     (resp[DATA_W-1:0]),
    .sum_o      (sum),
    .station_o  (station_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q   <= SQ_PROBE_REQ;
      wide_q <= 1'b0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (sq_q)
        SQ_PROBE_REQ:  if (start) sq_q <= SQ_PROBE_WAIT;
        SQ_PROBE_WAIT: if (resp_vld) begin
          // a large device keeps the line high until the address ends
          wide_q <= &resp[FRAME_W-1:DATA_W+1];
          addr_q <= '0;
          sq_q   <= SQ_READ_REQ;
        end
        SQ_READ_REQ:   if (start) sq_q <= SQ_READ_WAIT;
        SQ_READ_WAIT:  if (resp_vld) begin
          if (addr_q == last_addr) begin
            done_q <= 1'b1;
            sq_q   <= SQ_DONE;
          end else begin
            addr_q <= addr_q + 1'b1;
            sq_q   <= SQ_READ_REQ;
          end
        end
        SQ_DONE:       sq_q <= SQ_DONE;
        default:       sq_q <= SQ_PROBE_REQ;
      endcase
    end
  end

  assign done_o   = done_q;
  assign sum_ok_o = done_q && (sum == SIGNATURE);
endmodule

// File: rtl/ee_autosize_reader_chk.sv
module ee_autosize_reader_chk #(
  parameter int TICK_CYC = 125
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ee_sk_o,
  input logic        ee_cs_o,
  input logic        ee_di_o,
  input logic        done_o,
  input logic        sum_ok_o,
  input logic [47:0] station_addr_o
);
  logic [15:0] hi_len_q, lo_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len_q <= '0;
      lo_len_q <= '0;
    end else begin
      hi_len_q <= !ee_sk_o ? '0 : (&hi_len_q ? hi_len_q : hi_len_q + 1'b1);
      lo_len_q <= !(ee_cs_o && !ee_sk_o) ? '0 : (&lo_len_q ? lo_len_q : lo_len_q + 1'b1);
    end
  end

  // R7
  sk_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_sk_o |-> ee_cs_o);
  // R7
  cs_rise_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_cs_o) |-> !ee_sk_o);
  // R8
  high_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ee_sk_o) |-> hi_len_q >= 16'(TICK_CYC));
  // R8
  low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_sk_o) |-> lo_len_q >= 16'(TICK_CYC));
  // R2
  di_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));
  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R9
  quiet_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ee_cs_o);
  // R5
  ok_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_ok_o |-> done_o);
  // R6
  station_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(station_addr_o));
endmodule

bind ee_autosize_reader ee_autosize_reader_chk #(.TICK_CYC(TICK_CYC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ee_sk_o        (ee_sk_o),
  .ee_cs_o        (ee_cs_o),
  .ee_di_o        (ee_di_o),
  .done_o         (done_o),
  .sum_ok_o       (sum_ok_o),
  .station_addr_o (station_addr_o)
);

// File: tb/tb_ee_autosize_reader.sv
module tb_ee_autosize_reader;
  localparam int TICK  = 3;
  localparam int FRAME = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ee_sk, ee_cs, ee_di;
  logic        ee_do = 1'b1;
  logic        done, sum_ok;
  logic [47:0] sta;

  always #4 clk = ~clk;

  ee_autosize_reader #(.TICK_CYC(TICK)) dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ee_sk_o        (ee_sk),
    .ee_cs_o        (ee_cs),
    .ee_di_o        (ee_di),
    .ee_do_i        (ee_do),
    .done_o         (done),
    .sum_ok_o       (sum_ok),
    .station_addr_o (sta)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  int          dev_aw = 8;
  logic [15:0] mem [256];
  int          m_phase, m_cnt, m_lead, m_clk;
  logic [7:0]  m_addr;
  logic [1:0]  m_op;
  logic [15:0] m_word;
  logic        cs_last = 1'b0;
  int          n_acc = 0;
  int          acc_bad = 0;
  int          acc_lead [300];
  int          acc_addr [300];

  always @(ee_cs or posedge ee_sk) begin
    if (ee_cs !== cs_last) begin
      if (ee_cs === 1'b1) begin
        m_phase = 0; m_cnt = 0; m_lead = 0; m_clk = 0; m_addr = '0; m_op = '0;
        ee_do <= 1'b1;
      end else begin
        if (m_clk != FRAME || m_op != 2'b10 || m_phase != 3) acc_bad++;
        if (n_acc < 300) begin
          acc_lead[n_acc] = m_lead;
          acc_addr[n_acc] = int'(m_addr);
        end
        n_acc++;
        ee_do <= 1'b1;
      end
      cs_last = ee_cs;
    end else if (ee_sk === 1'b1 && ee_cs === 1'b1) begin
      m_clk++;
      case (m_phase)
        0: if (ee_di) begin m_phase = 1; m_cnt = 0; end
           else m_lead++;
        1: begin
          m_op = {m_op[0], ee_di};
          m_cnt++;
          if (m_cnt == 2) begin m_phase = 2; m_cnt = 0; m_addr = '0; end
        end
        2: begin
          m_addr = {m_addr[6:0], ee_di};
          m_cnt++;
          if (m_cnt == dev_aw) begin
            m_phase = 3; m_word = mem[m_addr]; m_cnt = 16;
            ee_do <= 1'b0;
          end
        end
        default: begin
          if (m_cnt > 0) begin ee_do <= m_word[m_cnt-1]; m_cnt--; end
          else ee_do <= 1'b1;
        end
      endcase
    end
  end

  // ---------------- timing monitor ----------------
  int   hi_run, lo_run, gap_run, min_hi, min_lo, min_gap, r7_bad;
  logic had_cs, cs_prev;

  always @(negedge clk) begin
    if (!rst_n) begin
      hi_run = 0; lo_run = 0; gap_run = 0;
      min_hi = 1000; min_lo = 1000; min_gap = 1000; r7_bad = 0;
      had_cs = 1'b0; cs_prev = 1'b0;
    end else begin
      if (ee_sk) hi_run++;
      else if (hi_run > 0) begin if (hi_run < min_hi) min_hi = hi_run; hi_run = 0; end
      if (ee_cs && !ee_sk) lo_run++;
      else if (lo_run > 0) begin if (lo_run < min_lo) min_lo = lo_run; lo_run = 0; end
      if (ee_cs) begin
        if (gap_run > 0 && had_cs && gap_run < min_gap) min_gap = gap_run;
        gap_run = 0; had_cs = 1'b1;
      end else gap_run++;
      if (ee_sk && !ee_cs) r7_bad++;
      if (ee_cs && !cs_prev && ee_sk) r7_bad++;
      cs_prev = ee_cs;
    end
  end

  // ---------------- helpers ----------------
  task automatic fill(input int aw, input bit good);
    int n;
    logic [15:0] s;
    n = 1 << aw;
    s = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h03B1 + 16'h0A5C);
    mem[0] = 16'hA1B2; mem[1] = 16'hC3D4; mem[2] = 16'hE5F6;
    for (int i = 0; i < n - 1; i++) s = s + mem[i];
    mem[n-1] = 16'hBABA - s + (good ? 16'h0 : 16'h0001);
  endtask

  function automatic bit exp_ok(input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem[i];
    return s == 16'hBABA;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    n_acc = 0;
    acc_bad = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic check_image(input int aw, input string tag);
    int n, bad;
    n = 1 << aw;
    bad = 0;
    chk(n_acc == n + 1, "R3", {tag, " access count"}, n_acc, n + 1);
    chk(acc_lead[0] == 1 && acc_addr[0] == 0, "R3", {tag, " probe pad/addr"},
        acc_lead[0] * 256 + acc_addr[0], 256);
    for (int k = 1; k <= n && k < 300; k++)
      if (acc_addr[k] != k - 1 || acc_lead[k] != 1 + 8 - aw) bad++;
    chk(bad == 0, "R4", {tag, " read order/pad"}, bad, 0);
    chk(acc_bad == 0, "R2", {tag, " frame shape"}, acc_bad, 0);
    chk(sum_ok == exp_ok(n), "R5", {tag, " sum flag"}, sum_ok, exp_ok(n));
    chk(sta == 48'hB2A1_D4C3_F6E5, "R6", {tag, " station address"}, sta, 48'hB2A1_D4C3_F6E5);
    chk(min_hi >= TICK && min_lo >= TICK, "R8", {tag, " phase width"},
        (min_hi < min_lo) ? min_hi : min_lo, TICK);
    chk(min_gap >= TICK, "R8", {tag, " cs gap"}, min_gap, TICK);
    chk(r7_bad == 0, "R7", {tag, " clock vs select"}, r7_bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ee_cs && !ee_sk && !done && !sum_ok && sta == '0, "R1", "reset outputs",
        {ee_cs, ee_sk, done, sum_ok, |sta}, 0);
  endtask

  task automatic t_run(input int aw, input bit good, input string tag);
    bit seen;
    int n_at_done;
    dev_aw = aw;
    fill(aw, good);
    do_reset();
    wait_done(seen);
    chk(seen, "R9", {tag, " done rises"}, seen, 1);
    repeat (TICK * 4) @(negedge clk);
    check_image(aw, tag);
    n_at_done = n_acc;
    repeat (400) @(negedge clk);
    chk(done && n_acc == n_at_done && !ee_cs, "R9", {tag, " quiet and sticky"},
        n_acc, n_at_done);
  endtask

  task automatic t_restart();
    bit seen;
    dev_aw = 8;
    fill(8, 1'b1);
    do_reset();
    for (int i = 0; i < 20000 && n_acc < 20; i++) @(negedge clk);
    repeat (TICK * 5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ee_cs && !done, "R10", "abort on reset", {ee_cs, done}, 0);
    repeat (2) @(posedge clk);
    n_acc = 0;
    acc_bad = 0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_done(seen);
    chk(seen, "R10", "done after restart", seen, 1);
    repeat (TICK * 4) @(negedge clk);
    check_image(8, "restart");
  endtask

  initial begin
    t_reset_state();
    t_run(8, 1'b1, "large good");
    t_run(6, 1'b1, "small good");
    t_run(6, 1'b0, "small bad");
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule